// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block drives a single 12-bit serial converter over three wires: an active-low select, a serial clock and a serial data return. When `run` is high, it starts conversions at a programmable spacing measured in system clocks. It produces the select and clock waveforms and shifts in a 16-bit frame. The four leading bits are checked and stripped, and the low twelve bits are presented in parallel together with a one-clock strobe.

The serial clock comes from the system clock, divided by twice `cfg_half_div`. The converter changes its output on falling serial edges, so the block samples on rising edges. Between frames the block holds off a new conversion until three conditions are met: the programmed period has elapsed, the select line has been high for the minimum quiet time, and the minimum acquisition time has passed. The acquisition time is counted from the falling serial edge 2.5 periods before the end of the frame. If any leading bit reads as one, the block flags that sample and sets a flag that stays set until reset.

Top module: `adc_frame_reader`

## Requirements
- R1: A frame is a falling edge of `adc_cs_n` followed by exactly 16 serial clock cycles, each made of a low half and then a high half. `adc_cs_n` returns high on the 16th rising edge of `adc_sclk`, and `adc_sclk` then stays high.
- R2: In reset and while idle, `adc_cs_n` and `adc_sclk` are both 1. Out of reset, `smp_valid` and `err_sticky` are 0.
- R3: The first falling edge of `adc_sclk` comes SETUP_CYC system clocks after `adc_cs_n` falls. Each serial half period lasts `cfg_half_div` system clocks, and a value of 0 is treated as 1.
- R4: Bits are captured on rising `adc_sclk` edges, most significant first. `smp_data` receives the last 12 bits of the frame (bit 11 first). `smp_valid` is high for exactly one clock, in the same cycle that `adc_cs_n` is first seen high again.
- R5: `adc_cs_n` stays high for at least QUIET_CYC system clocks between frames.
- R6: At least ACQ_CYC system clocks pass between the 14th falling `adc_sclk` edge of a frame and the next falling edge of `adc_cs_n`.
- R7: While `run` stays high, consecutive falling edges of `adc_cs_n` are exactly max(`cfg_period`, SETUP_CYC+31*half+QUIET_CYC, SETUP_CYC+26*half+ACQ_CYC) clocks apart.
- R8: `smp_frm_err` is 1 together with a sample when any of the first four bits of its frame is 1. `smp_data` still carries the 12 data bits.
- R9: `err_sticky` becomes 1 with the first flagged sample and stays 1 until reset.
- R10: Lowering `run` starts no new frame, but a frame already in progress completes and delivers its sample.
- R11: After reset, or after a long idle time, `adc_cs_n` falls on the first clock edge at which `run` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Keep converting while high |
| cfg_half_div | input | DIV_W | Serial half period in system clocks |
| cfg_period | input | PER_W | Minimum spacing of conversion starts in system clocks |
| adc_cs_n | output | 1 | Active-low converter select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_sdata | input | 1 | Serial data from the converter |
| smp_data | output | 12 | Last captured result |
| smp_valid | output | 1 | One-clock strobe for a new result |
| smp_frm_err | output | 1 | Leading-bit error for the current result |
| err_sticky | output | 1 | Set by any leading-bit error, cleared by reset |

## Verification
The assertions take three things for granted. First, `cfg_half_div` and `cfg_period` do not change while a frame is in flight or while `run` is high. Second, the converter drives `adc_sdata` only while selected. Third, the converter changes `adc_sdata` only on falling serial edges, so the value is settled by the next rising edge. The stimulus follows these rules: it reprograms the configuration only with `run` low and after the select line has gone idle. Its converter model moves to the next bit on each falling serial edge and releases the line whenever select is high. The timing windows are checked against three configurations, chosen so that the period, the quiet time and the acquisition time each in turn sets the spacing.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int DATA_BITS  = FRAME_BITS - LEAD_BITS;
  // value of the rising-edge count when the falling edge that opens the
  // acquisition window (2.5 serial periods before frame end) is issued
  localparam int ACQ_FALL_IDX = FRAME_BITS - 3;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_SHIFT
  } seq_state_t;
endpackage

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int SETUP_CYC = 3   // must be at least 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DIV_W-1:0]      cfg_half,
  input  logic                  go,
  output logic                  launch,
  output logic                  cs_n,
  output logic                  sclk,
  input  logic                  sdata,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic                  acq_mark
);
  localparam int SET_W = $clog2(SETUP_CYC + 1);
  localparam int PH_W  = (DIV_W > SET_W) ? DIV_W : SET_W;
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  seq_state_t            st;
  logic [PH_W-1:0]       ph;
  logic [BIT_W-1:0]      bits;
  logic [FRAME_BITS-2:0] sr;
  logic [DIV_W-1:0]      half_eff;
  logic                  tick, setup_end, rise_now, fall_now;

  always_comb begin
    half_eff   = (cfg_half == '0) ? DIV_W'(1) : cfg_half;
    tick       = (ph == PH_W'(half_eff) - PH_W'(1));
    setup_end  = (ph == PH_W'(SETUP_CYC - 1));
    launch     = (st == SQ_IDLE) && go;
    rise_now   = (st == SQ_SHIFT) && tick && !sclk;
    fall_now   = (st == SQ_SHIFT) && tick && sclk;
    frame_done = rise_now && (bits == BIT_W'(FRAME_BITS - 1));
    acq_mark   = fall_now && (bits == BIT_W'(ACQ_FALL_IDX));
    frame_word = {sr, sdata};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      ph   <= '0;
      bits <= '0;
      cs_n <= 1'b1;
      sclk <= 1'b1;
      sr   <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (go) begin
            st   <= SQ_SETUP;
            cs_n <= 1'b0;
            ph   <= '0;
          end
        end
        SQ_SETUP: begin
          if (setup_end) begin
            st   <= SQ_SHIFT;
            ph   <= '0;
            bits <= '0;
            sclk <= 1'b0;
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        SQ_SHIFT: begin
          if (tick) begin
            ph   <= '0;
            sclk <= ~sclk;
            if (!sclk) begin
              sr   <= frame_word[FRAME_BITS-2:0];
              bits <= bits + BIT_W'(1);
              if (frame_done) begin
                cs_n <= 1'b1;
                st   <= SQ_IDLE;
              end
            end
          end else begin
            ph <= ph + PH_W'(1);
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R2: the serial clock is parked high whenever the converter is deselected
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  // R1: select only returns high on a rising serial edge
  p_cs_rise_on_edge_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $rose(sclk));
endmodule

// File: rtl/adc_rd_space.sv
module adc_rd_space #(
  parameter int PER_W     = 16,
  parameter int TMR_W     = 8,
  parameter int QUIET_CYC = 13,
  parameter int ACQ_CYC   = 63
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             launch,
  input  logic             acq_mark,
  input  logic [PER_W-1:0] cfg_period,
  output logic             ok
);
  logic [TMR_W-1:0] q_cnt, a_cnt;
  logic [PER_W-1:0] p_cnt;

  always_comb
    ok = (q_cnt >= TMR_W'(QUIET_CYC)) && (a_cnt >= TMR_W'(ACQ_CYC)) &&
         (p_cnt >= cfg_period);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_cnt <= '1;
      a_cnt <= '1;
      p_cnt <= '1;
    end else begin
      // cycles select has been high, counting the current one
      if (!cs_n)              q_cnt <= TMR_W'(1);
      else if (q_cnt != '1)   q_cnt <= q_cnt + TMR_W'(1);
      // cycles since the acquisition-opening serial fall
      if (acq_mark)           a_cnt <= TMR_W'(1);
      else if (a_cnt != '1)   a_cnt <= a_cnt + TMR_W'(1);
      // cycles since the last conversion start
      if (launch)             p_cnt <= PER_W'(1);
      else if (p_cnt != '1)   p_cnt <= p_cnt + PER_W'(1);
    end
  end

  p_quiet_gap_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(q_cnt) >= TMR_W'(QUIET_CYC));

  p_acq_window_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(a_cnt) >= TMR_W'(ACQ_CYC));

  p_period_floor_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(p_cnt) >= $past(cfg_period));
endmodule

// File: rtl/adc_rd_out.sv
module adc_rd_out
  import adc_rd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_word,
  output logic [DATA_BITS-1:0]  data,
  output logic                  valid,
  output logic                  err,
  output logic                  sticky
);
  logic lead_bad;

  always_comb lead_bad = |frame_word[FRAME_BITS-1:DATA_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      data   <= '0;
      valid  <= 1'b0;
      err    <= 1'b0;
      sticky <= 1'b0;
    end else begin
      valid <= frame_done;
      if (frame_done) begin
        data <= frame_word[DATA_BITS-1:0];
        err  <= lead_bad;
        if (lead_bad) sticky <= 1'b1;
      end
    end
  end

  p_one_clk_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_sticky_holds_r9: assert property (@(posedge clk) disable iff (rst)
    $past(sticky) |-> sticky);

  p_err_sets_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (valid && err) |-> sticky);
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int PER_W     = 16,
  parameter int TMR_W     = 8,
  parameter int SETUP_CYC = 3,
  parameter int QUIET_CYC = 13,
  parameter int ACQ_CYC   = 63
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic [DIV_W-1:0]     cfg_half_div,
  input  logic [PER_W-1:0]     cfg_period,
  output logic                 adc_cs_n,
  output logic                 adc_sclk,
  input  logic                 adc_sdata,
  output logic [DATA_BITS-1:0] smp_data,
  output logic                 smp_valid,
  output logic                 smp_frm_err,
  output logic                 err_sticky
);
  logic                  space_ok, go, launch, frame_done, acq_mark;
  logic [FRAME_BITS-1:0] frame_word;

  always_comb go = run && space_ok;

  adc_rd_seq #(
    .DIV_W     (DIV_W),
    .SETUP_CYC (SETUP_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .cfg_half   (cfg_half_div),
    .go         (go),
    .launch     (launch),
    .cs_n       (adc_cs_n),
    .sclk       (adc_sclk),
    .sdata      (adc_sdata),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .acq_mark   (acq_mark)
  );

  adc_rd_space #(
    .PER_W     (PER_W),
    .TMR_W     (TMR_W),
    .QUIET_CYC (QUIET_CYC),
    .ACQ_CYC   (ACQ_CYC)
  ) u_space (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (adc_cs_n),
    .launch     (launch),
    .acq_mark   (acq_mark),
    .cfg_period (cfg_period),
    .ok         (space_ok)
  );

  adc_rd_out u_out (
    .clk        (clk),
    .rst        (rst),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .data       (smp_data),
    .valid      (smp_valid),
    .err        (smp_frm_err),
    .sticky     (err_sticky)
  );

  // R1: every result arrives exactly as the frame closes
  p_result_at_frame_end_r1: assert property (@(posedge clk) disable iff (rst)
    smp_valid |-> $rose(adc_cs_n));

  // R10: a frame never starts with run low
  p_no_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_cs_n) |-> $past(run));
endmodule

// File: tb/sim_adc_frame_reader.sv
`timescale 1ns/1ps
module sim_adc_frame_reader;
  localparam int S = 3;
  localparam int Q = 13;
  localparam int A = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [7:0]  cfg_half_div = 8'd2;
  logic [15:0] cfg_period = 16'd0;
  logic        adc_cs_n, adc_sclk;
  wire         adc_sdata;
  logic [11:0] smp_data;
  logic        smp_valid, smp_frm_err, err_sticky;

  always #2 clk = ~clk;

  adc_frame_reader #(
    .DIV_W(8), .PER_W(16), .TMR_W(8),
    .SETUP_CYC(S), .QUIET_CYC(Q), .ACQ_CYC(A)
  ) u0 (
    .clk(clk), .rst(rst), .run(run),
    .cfg_half_div(cfg_half_div), .cfg_period(cfg_period),
    .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata),
    .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_frm_err(smp_frm_err), .err_sticky(err_sticky)
  );

  // converter model: first bit at select fall, next bit on each serial fall
  logic [15:0] mword = 16'h0000;
  logic        mbit = 1'b0;
  int          mfall = 0;
  assign adc_sdata = adc_cs_n ? 1'bz : mbit;

  always @(negedge adc_cs_n) begin
    mfall = 0;
    mbit  = mword[15];
  end
  always @(negedge adc_sclk) begin
    if (!adc_cs_n) begin
      mfall = mfall + 1;
      if (mfall <= 16) mbit = mword[16 - mfall];
    end
  end

  // monitor, sampled away from the active edge
  int  cyc = 0, cs_fall = 0, cs_fall_prev = 0, cs_rise = 0;
  int  f1 = 0, f2 = 0, f14 = 0, nf = 0, ncsf = 0;
  int  gap_q = 0, gap_a = 0, vcnt = 0, v_cyc = 0;
  logic [11:0] v_data = '0;
  logic        v_err = 1'b0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (prev_cs && !adc_cs_n) begin
      cs_fall_prev = cs_fall;
      cs_fall = cyc;
      gap_q = cyc - cs_rise;
      gap_a = cyc - f14;
      nf = 0;
      ncsf = ncsf + 1;
    end
    if (!prev_cs && adc_cs_n) cs_rise = cyc;
    if (prev_sclk && !adc_sclk && !adc_cs_n) begin
      nf = nf + 1;
      if (nf == 1)  f1 = cyc;
      if (nf == 2)  f2 = cyc;
      if (nf == 14) f14 = cyc;
    end
    if (smp_valid) begin
      vcnt = vcnt + 1;
      v_cyc = cyc;
      v_data = smp_data;
      v_err = smp_frm_err;
    end
    prev_cs = adc_cs_n;
    prev_sclk = adc_sclk;
  end

  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sync();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sync();
  endtask

  task automatic wait_valids(input int n);
    int tgt;
    tgt = vcnt + n;
    while (vcnt < tgt) @(negedge clk);
    #1;
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    run = 1'b0;
    idle(5);
    chk("R2 cs_n in reset", adc_cs_n, 1);
    chk("R2 sclk in reset", adc_sclk, 1);
    rst = 1'b0;
    idle(3);
    chk("R2 valid after reset", smp_valid, 0);
    chk("R9 sticky cleared by reset", err_sticky, 0);
    chk("R2 cs_n idle", adc_cs_n, 1);
  endtask

  task automatic t_first_frame();
    int c, v0;
    cfg_half_div = 8'd2;
    cfg_period = 16'd0;
    mword = 16'h0ABC;
    v0 = vcnt;
    sync();
    c = cyc;
    run = 1'b1;
    wait_valids(1);
    run = 1'b0;
    chk("R11 select falls at first run edge", cs_fall, c + 1);
    chk("R3 setup to first serial fall", f1 - cs_fall, S);
    chk("R3 serial period", f2 - f1, 4);
    chk("R1 select low span", cs_rise - cs_fall, S + 31 * 2);
    chk("R1 serial cycles per frame", nf, 16);
    chk("R4 result data", int'(v_data), 12'hABC);
    chk("R4 strobe with select rise", v_cyc, cs_rise);
    chk("R8 clean frame flag", v_err, 0);
    idle(20);
    chk("R4 strobe one clock", vcnt - v0, 1);
    chk("R1 sclk parked high", adc_sclk, 1);
  endtask

  task automatic t_rate(input int half, input int per, input logic [15:0] w);
    int expv;
    idle(1100);
    cfg_half_div = 8'(half);
    cfg_period = 16'(per);
    mword = w;
    sync();
    run = 1'b1;
    wait_valids(2);
    run = 1'b0;
    expv = max3(per, S + 31 * half + Q, S + 26 * half + A);
    chk("R7 start spacing", cs_fall - cs_fall_prev, expv);
    chk("R5 quiet gap met", (gap_q >= Q) ? 1 : 0, 1);
    chk("R6 acquisition window met", (gap_a >= A) ? 1 : 0, 1);
    chk("R3 serial period", f2 - f1, 2 * half);
    chk("R4 data", int'(v_data), int'(w[11:0]));
  endtask

  task automatic t_one(input logic [15:0] w, input int err_exp, input int st_exp);
    idle(200);
    cfg_half_div = 8'd2;
    cfg_period = 16'd0;
    mword = w;
    sync();
    run = 1'b1;
    wait_valids(1);
    run = 1'b0;
    chk("R8 frame error flag", v_err, err_exp);
    chk("R8 data despite flag", int'(v_data), int'(w[11:0]));
    chk("R9 sticky flag", err_sticky, st_exp);
  endtask

  task automatic t_stop();
    int v0, n0;
    idle(200);
    cfg_half_div = 8'd4;
    cfg_period = 16'd0;
    mword = 16'h0777;
    v0 = vcnt;
    n0 = ncsf;
    sync();
    run = 1'b1;
    while (ncsf == n0) @(negedge clk);
    #1;
    run = 1'b0;
    idle(1500);
    chk("R10 frame in flight completes", vcnt - v0, 1);
    chk("R10 no new frame", ncsf - n0, 1);
    chk("R10 select idle", adc_cs_n, 1);
    chk("R10 data", int'(v_data), 12'h777);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_first_frame();
    t_rate(2, 0, 16'h0F0F);      // acquisition sets the spacing
    t_rate(12, 0, 16'h0555);     // quiet time sets the spacing
    t_rate(25, 1000, 16'h0AAA);  // programmed period sets the spacing
    t_one(16'h8123, 1, 1);
    t_one(16'h0456, 0, 1);
    t_one(16'h1FFF, 1, 1);
    t_stop();
    t_reset();
    finish_run();
  end
endmodule